// File: doc/BRIEF.md
# Trace Address Field Chunk Serializer

This block turns one instruction address into the variable-length address field of a trace message. The field value is the address with its always-zero bit 0 removed. It is sent as a stream of bytes. Each byte carries a 6-bit data chunk and a 2-bit end code. Chunks go out least-significant first, and the end code marks the final byte. A start strobe captures the address, the address width (32 or 64 bits) and the extension enable. In that same cycle a leading-bit detector works out how many chunks are needed. The shifter then presents one byte per accepted valid/ready handshake.

With extension disabled, only leading zero bits are dropped. With extension enabled, a leading run of ones or of zeros may be dropped, as long as the receiver can rebuild it. The receiver rebuilds the run by copying the top data bit of the final byte up to the top field bit. The block therefore sends the shortest whole number of chunks whose top bit, replicated upward, reproduces the field. Where the top bit would wrongly imply ones, it adds an all-zero chunk. An address that is not canonical is still encoded in full.

Top module: `mdo_addr_serializer`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a start is accepted.
- R2: Every byte carries a data chunk in bits 7:2 and an end code in bits 1:0. The end code is 00 for a continuation byte and 01 for the final byte. `out_last` is high exactly on the final byte. Chunks are taken from the field value (address bits XLEN-1:1) starting at field bit 0, six bits at a time. Bits above the field are sent as zero.
- R3: With extension disabled, the chunk count is the smallest that covers every set bit of the field, with a minimum of one. A zero address gives the single byte 0x01.
- R4: With extension enabled, the chunk count is the smallest k for which copying bit 6k-1 upward reproduces the field. Leading ones are trimmed this way: address 0xFFFF_FFFE_3FFF_FFFE gives FC FC FC FC 7C F1.
- R5: With extension enabled, a field whose significant bits end in a set bit on a chunk boundary gets an extra all-zero chunk. Address 0x1F_FFFF_FFFE gives seven bytes, the last being 0x01; with extension disabled the same address gives six bytes, the last being 0xFD.
- R6: In 64-bit mode a field that no trimming can shorten is sent as 11 bytes. Address 0xBFFF_FFFF_FFFF_FFFE ends with byte 0x15 in either mode.
- R7: In 32-bit mode the field is address bits 31:1, and address bits 63:32 have no effect. The stream never exceeds six bytes.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: A start raised while a stream is in progress is ignored. The running stream is unchanged, and no second stream follows it.
- R10: `out_valid` rises in the cycle after an accepted start. The stream advances one byte per handshake and drops `out_valid` in the cycle after the final byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe, accepted when no stream is active |
| addr | input | 64 | Address to encode |
| wide | input | 1 | 1: 64-bit address width, 0: 32-bit |
| ext_en | input | 1 | Enables trimming of redundant leading ones or zeros |
| out_ready | input | 1 | Consumer accepts the presented byte |
| out_valid | output | 1 | A byte is presented |
| out_data | output | 8 | Data chunk in bits 7:2, end code in bits 1:0 |
| out_last | output | 1 | Presented byte is the final byte of the field |

## Verification
The hardest case to reach from the ports is the boundary where the top significant bit is set and falls exactly on a chunk edge. There, trimming must stop one chunk later than the zero-only rule would suggest. The stimulus targets it with an address whose field is 36 ones, sent with and without extension. It also uses a case where the ones run stops two bits into a chunk, and a non-canonical 64-bit address. A second difficulty is a start arriving mid-stream under back-pressure. The bench raises start with a different address while `out_ready` alternates. It then confirms that the bytes match the first address and that nothing follows the final byte.

// File: rtl/mdo_ser_pkg.sv
package mdo_ser_pkg;

    localparam int CHUNK_W = 6;
    localparam int CODE_W  = 2;
    localparam int RUN_W   = 64;

    typedef enum logic [CODE_W-1:0] {
        SEG_MORE = 2'b00,
        SEG_END  = 2'b01
    } seg_code_e;

    typedef struct packed {
        logic [CHUNK_W-1:0] chunk;
        seg_code_e          code;
    } mdo_byte_t;

    // Length of the run of bits equal to bitval, counted down from bit width-1.
    function automatic logic [6:0] top_run(input logic [RUN_W-1:0] val,
                                           input logic [6:0] width,
                                           input logic bitval);
        logic [6:0] n;
        logic       hit;
        n   = '0;
        hit = 1'b0;
        for (int i = RUN_W - 1; i >= 0; i--) begin
            if (i < int'(width) && !hit) begin
                if (val[i] == bitval) n = n + 7'd1;
                else                  hit = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/mdo_len_calc.sv
module mdo_len_calc
    import mdo_ser_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-2:0] field,
    input  logic              wide,
    input  logic              ext_en,
    output logic [CNT_W-1:0]  chunks
);
    localparam int FIELD_W       = ADDR_W - 1;
    localparam int NARROW_CHUNKS = (NARROW_W - 1 + CHUNK_W - 1) / CHUNK_W;

    logic [RUN_W-1:0] fpad;
    logic [6:0]       width;
    logic             top_bit;
    logic [6:0]       zeros_run;
    logic [6:0]       same_run;
    logic [6:0]       need_bits;
    logic [7:0]       want;
    logic [7:0]       cap;

    always_comb begin
        fpad      = RUN_W'(field);
        width     = wide ? 7'(FIELD_W) : 7'(NARROW_W - 1);
        top_bit   = fpad[6'(width - 7'd1)];
        zeros_run = top_run(fpad, width, 1'b0);
        same_run  = top_run(fpad, width, top_bit);
        need_bits = ext_en ? (width - same_run + 7'd1) : (width - zeros_run);
        if (need_bits == 7'd0) need_bits = 7'd1;
        want = (8'(need_bits) + 8'(CHUNK_W - 1)) / 8'(CHUNK_W);
        cap  = (8'(width) + 8'(CHUNK_W - 1)) / 8'(CHUNK_W);
        chunks = (want > cap) ? CNT_W'(cap) : CNT_W'(want);
    end

    AST_NARROW_BOUND: assert property (@(posedge clk) disable iff (rst)
        !wide |-> (chunks != '0 && 32'(chunks) <= NARROW_CHUNKS)); // R7

    AST_PLAIN_MINIMAL: assert property (@(posedge clk) disable iff (rst)
        (!ext_en && chunks > 1) |-> ((fpad >> (CHUNK_W * (32'(chunks) - 1))) != '0)); // R3

    AST_EXT_NO_LONGER: assert property (@(posedge clk) disable iff (rst)
        ext_en |-> (32'(chunks) <= (FIELD_W + CHUNK_W) / CHUNK_W)); // R6

endmodule

// File: rtl/mdo_shifter.sv
module mdo_shifter
    import mdo_ser_pkg::*;
#(
    parameter int MAX_CHUNKS = 11,
    parameter int CNT_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [MAX_CHUNKS*CHUNK_W-1:0] load_bits,
    input  logic [CNT_W-1:0]              load_count,
    input  logic                          ready,
    output logic                          valid,
    output mdo_byte_t                     byte_o,
    output logic                          last
);
    localparam int SHIFT_W = MAX_CHUNKS * CHUNK_W;

    logic [SHIFT_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (left_q == '0) begin
            if (load) begin
                sh_q   <= load_bits;
                left_q <= load_count;
            end
        end else if (ready) begin
            sh_q   <= sh_q >> CHUNK_W;
            left_q <= left_q - CNT_W'(1);
        end
    end

    always_comb begin
        valid        = (left_q != '0);
        last         = (left_q == CNT_W'(1));
        byte_o.chunk = sh_q[CHUNK_W-1:0];
        byte_o.code  = last ? SEG_END : SEG_MORE;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(byte_o) && $stable(last))); // R8

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && last) |=> !valid); // R10

endmodule

// File: rtl/mdo_addr_serializer.sv
module mdo_addr_serializer
    import mdo_ser_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic              ext_en,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int FIELD_W    = ADDR_W - 1;
    localparam int MAX_CHUNKS = (FIELD_W + CHUNK_W - 1) / CHUNK_W;
    localparam int SHIFT_W    = MAX_CHUNKS * CHUNK_W;
    localparam int CNT_W      = $clog2(MAX_CHUNKS + 1);

    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   chunks;
    mdo_byte_t          cur_byte;
    logic               unused_lsb;

    assign unused_lsb = addr[0];

    always_comb begin
        if (wide) field = addr[ADDR_W-1:1];
        else      field = FIELD_W'(addr[NARROW_W-1:1]);
    end

    mdo_len_calc #(
        .ADDR_W  (ADDR_W),
        .NARROW_W(NARROW_W),
        .CNT_W   (CNT_W)
    ) u_len (
        .clk   (clk),
        .rst   (rst),
        .field (field),
        .wide  (wide),
        .ext_en(ext_en),
        .chunks(chunks)
    );

    mdo_shifter #(
        .MAX_CHUNKS(MAX_CHUNKS),
        .CNT_W     (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_bits (SHIFT_W'(field)),
        .load_count(chunks),
        .ready     (out_ready),
        .valid     (out_valid),
        .byte_o    (cur_byte),
        .last      (out_last)
    );

    assign out_data = cur_byte;

    AST_START_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        (start && !out_valid) |=> out_valid); // R10

    AST_STREAM_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> out_valid); // R10

    AST_LAST_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[1:0] == (out_last ? 2'b01 : 2'b00))); // R2

endmodule

// File: tb/sim_mdo_addr_serializer.sv
`timescale 1ns/1ps
module sim_mdo_addr_serializer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] addr = '0;
    logic        wide = 1'b1;
    logic        ext_en = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] got [0:15];
    int         got_n;

    always #2.5 clk = ~clk;

    mdo_addr_serializer u0 (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .wide(wide),
        .ext_en(ext_en), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [62:0] field_of(input logic [63:0] a, input bit w);
        return w ? a[63:1] : {32'b0, a[31:1]};
    endfunction

    function automatic int model_chunks(input logic [62:0] v, input int w, input bit ext);
        for (int k = 1; k <= 11; k++) begin
            if (6 * k >= w) return k;
            if (!ext) begin
                if ((v >> (6 * k)) == '0) return k;
            end else begin
                logic [62:0] msk;
                logic [62:0] low;
                logic [62:0] rec;
                msk = (63'd1 << w) - 63'd1;
                low = (63'd1 << (6 * k)) - 63'd1;
                rec = v & low;
                if (v[6 * k - 1]) rec = rec | (msk & ~low);
                if (rec == (v & msk)) return k;
            end
        end
        return 11;
    endfunction

    task automatic run_stream(input logic [63:0] a, input bit w, input bit ext,
                              input bit stall, input bit inject, input string req);
        logic [62:0] v;
        logic [65:0] vpad;
        int          n_exp;
        logic [7:0]  held;
        logic        held_last;
        bit          done;
        v     = field_of(a, w);
        vpad  = {3'b0, v};
        n_exp = model_chunks(v, w ? 63 : 31, ext);
        @(negedge clk);
        addr = a; wide = w; ext_en = ext; start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        got_n = 0;
        done  = 0;
        for (int cyc = 0; cyc < 40 && !done; cyc++) begin
            logic rdy;
            if (!out_valid) begin
                check(0, "R10 stream dropped early", 0, 1);
                done = 1;
            end else begin
                rdy = (stall && (cyc % 2 == 0)) ? 1'b0 : 1'b1;
                out_ready = rdy;
                if (inject && cyc == 1) begin
                    start = 1'b1;
                    addr  = ~a;
                    ext_en = ~ext;
                end else begin
                    start = 1'b0;
                end
                if (rdy) begin
                    if (got_n < 16) got[got_n] = out_data;
                    check(out_last == (got_n == n_exp - 1), {req, " R2 last flag"}, out_last, (got_n == n_exp - 1));
                    got_n++;
                    if (out_last) done = 1;
                end else begin
                    held = out_data;
                    held_last = out_last;
                end
                @(negedge clk);
                if (!rdy)
                    check(out_valid && out_data == held && out_last == held_last,
                          "R8 hold under stall", out_data, held);
            end
        end
        out_ready = 1'b0;
        start = 1'b0;
        check(!out_valid, "R10 idle after final byte", out_valid, 0);
        if (inject) begin
            repeat (3) @(negedge clk);
            check(!out_valid, "R9 no stream from mid-stream start", out_valid, 0);
        end
        check(got_n == n_exp, {req, " byte count"}, got_n, n_exp);
        for (int i = 0; i < got_n && i < 16; i++) begin
            logic [7:0] e;
            e = {vpad[6 * i +: 6], (i == n_exp - 1) ? 2'b01 : 2'b00};
            check(got[i] == e, {req, " R2 byte content"}, got[i], e);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 valid low in reset", out_valid, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!out_valid, "R1 valid low after reset", out_valid, 0);
    endtask

    task automatic t_zero();
        run_stream(64'h0, 1, 0, 0, 0, "R3 zero plain");
        check(got_n == 1 && got[0] == 8'h01, "R3 zero byte", got[0], 8'h01);
        run_stream(64'h0, 1, 1, 0, 0, "R4 zero ext");
        check(got_n == 1 && got[0] == 8'h01, "R4 zero byte ext", got[0], 8'h01);
    endtask

    task automatic t_boundary();
        run_stream(64'h1F_FFFF_FFFE, 1, 0, 0, 0, "R5 plain");
        check(got_n == 6 && got[5] == 8'hFD, "R5 plain six bytes", got[5], 8'hFD);
        run_stream(64'h1F_FFFF_FFFE, 1, 1, 0, 0, "R5 ext");
        check(got_n == 7 && got[6] == 8'h01, "R5 extra zero chunk", got[6], 8'h01);
    endtask

    task automatic t_trim_ones();
        run_stream(64'hFFFF_FFFE_3FFF_FFFE, 1, 1, 0, 0, "R4 trim");
        check(got_n == 6, "R4 trim count", got_n, 6);
        check(got[0] == 8'hFC && got[3] == 8'hFC, "R4 ones chunks", got[3], 8'hFC);
        check(got[4] == 8'h7C, "R4 fifth byte", got[4], 8'h7C);
        check(got[5] == 8'hF1, "R4 final byte", got[5], 8'hF1);
        run_stream(64'hFFFF_FFFF_8000_31F4, 1, 1, 0, 0, "R4 kernel ext");
        check(got_n == 6, "R4 kernel ext count", got_n, 6);
        run_stream(64'hFFFF_FFFF_8000_31F4, 1, 0, 0, 0, "R3 kernel plain");
        check(got_n == 11, "R3 kernel plain count", got_n, 11);
    endtask

    task automatic t_noncanon();
        run_stream(64'hBFFF_FFFF_FFFF_FFFE, 1, 1, 0, 0, "R6 ext");
        check(got_n == 11 && got[10] == 8'h15, "R6 full ext", got[10], 8'h15);
        run_stream(64'hBFFF_FFFF_FFFF_FFFE, 1, 0, 0, 0, "R6 plain");
        check(got_n == 11 && got[10] == 8'h15, "R6 full plain", got[10], 8'h15);
    endtask

    task automatic t_narrow();
        run_stream(64'hFFFF_FFFE, 0, 1, 0, 0, "R7 ext");
        check(got_n == 1 && got[0] == 8'hFD, "R7 narrow ext one byte", got[0], 8'hFD);
        run_stream(64'hFFFF_FFFE, 0, 0, 0, 0, "R7 plain");
        check(got_n == 6, "R7 narrow plain six", got_n, 6);
        run_stream(64'hABCD_0000_0000_0010, 0, 0, 0, 0, "R7 upper ignored");
        check(got_n == 1 && got[0] == 8'h21, "R7 upper bits no effect", got[0], 8'h21);
    endtask

    task automatic t_stall_inject();
        run_stream(64'hFFFF_FFFE_3FFF_FFFE, 1, 1, 1, 1, "R9 inject stall");
        check(got_n == 6 && got[5] == 8'hF1, "R9 stream unchanged", got[5], 8'hF1);
        run_stream(64'h1234_5678_9ABC_DEF0, 1, 0, 1, 0, "R8 stall plain");
    endtask

    initial begin
        t_reset();
        t_zero();
        t_boundary();
        t_trim_ones();
        t_noncanon();
        t_narrow();
        t_stall_inject();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule